// File: doc/BRIEF.md
# Free-Running 64-bit Timer with Periodic Compare

The block is a 64-bit up-counter that is advanced by a programmable clock divider and watched by a 64-bit comparator. Software reaches all of its state through a 32-bit register bus. Every 64-bit quantity is split into a low and a high word, and each word is read or written on its own. When the comparator is armed and the count has reached or passed the comparator value, a sticky status flag is raised. That flag, gated by an interrupt enable, drives the single interrupt line.

For periodic events, an auto-increment mode adds a programmable 32-bit step to the comparator on every matching cycle. The next event is then scheduled without software touching the comparator. The counter words can only be loaded while the timer is stopped, so a load never races with a count.

Top module: `gcnt_timer`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: Word offsets are part of the interface. 0x00 is count low, 0x04 count high, 0x08 control, 0x0C status, 0x10 comparator low, 0x14 comparator high and 0x18 step. A read of 0x1C, or of any address whose bits 1:0 are not zero, returns zero, and writes to those addresses change nothing.
- R2 (control layout): bit 0 is run, bit 1 is compare enable, bit 2 is interrupt enable, bit 3 is auto-increment enable and bits 15:8 are the divider value P. All other control bits read as zero.
- R3: While run is set, the count increases by one once every P+1 clock edges, with the carry passing from the low word to the high word. The first increment comes on the (P+1)th edge after the edge that sets run.
- R4: Writes to either count word take effect only while run is clear; while running they are ignored.
- R5: In any cycle where compare enable is set and count >= comparator, status bit 0 is set at the next edge and stays set.
- R6: Writing status with bit 0 = 1 clears the flag and writing 0 has no effect. A match in the same cycle wins over the clear.
- R7: With auto-increment enabled, each matching cycle adds the zero-extended step to the comparator. A bus write to a comparator word in the same cycle takes priority for that word. Without auto-increment, the comparator changes only by bus writes.
- R8: `irq` is high exactly when the status flag and the interrupt enable are both set.
- R9: While run is clear, the count holds its value and the divider phase returns to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; combinational, zero when not selected |
| irq | output | 1 | Interrupt line |

## Verification
On every cycle, the assertions check the following: a running count moves by at most one per cycle, and with a non-zero divider never on two cycles in a row. A stopped count moves only on a word write. A match always sets the sticky flag, which falls only on a write-one-to-clear. The comparator stays put when auto-increment is off, and a rising interrupt implies flag and enable. The exact period of P+1 edges, the carry into the high word, the schedule of successive auto-increment steps, the priority of bus writes over the step and over the clear, and the address map can only be shown by the bench's timed scenarios, which compare read-back values against counts computed from the edges elapsed.

// File: rtl/gcnt_pkg.sv
package gcnt_pkg;

    localparam int WORD_W  = 32;
    localparam int NWORDS  = 2;
    localparam int CNT_W   = WORD_W * NWORDS;
    localparam int PRE_W   = 8;
    localparam int PRE_LSB = 8;
    localparam int ADDR_W  = 5;

    // word index (bus_addr[4:2]) of each register
    typedef enum logic [2:0] {
        RG_CNT_LO = 3'd0,
        RG_CNT_HI = 3'd1,
        RG_CTRL   = 3'd2,
        RG_STAT   = 3'd3,
        RG_CMP_LO = 3'd4,
        RG_CMP_HI = 3'd5,
        RG_STEP   = 3'd6,
        RG_NONE   = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic [PRE_W-1:0] prescale;
        logic             step_en;
        logic             irq_en;
        logic             cmp_en;
        logic             run;
    } ctrl_t;

    typedef struct packed {
        logic cnt_lo;
        logic cnt_hi;
        logic ctrl;
        logic stat;
        logic cmp_lo;
        logic cmp_hi;
        logic step;
    } wr_strobe_t;

    function automatic reg_sel_e decode_addr(logic [ADDR_W-1:0] a);
        if (a[1:0] != 2'b00) return RG_NONE;
        return reg_sel_e'(a[4:2]);
    endfunction

    function automatic logic [WORD_W-1:0] ctrl_pack(ctrl_t c);
        logic [WORD_W-1:0] r;
        r = '0;
        r[PRE_LSB +: PRE_W] = c.prescale;
        r[3:0] = {c.step_en, c.irq_en, c.cmp_en, c.run};
        return r;
    endfunction

    // replace the selected 32-bit lanes of a wide value
    function automatic logic [CNT_W-1:0] merge_words(
        logic [CNT_W-1:0]  base,
        logic [NWORDS-1:0] sel,
        logic [WORD_W-1:0] d
    );
        logic [CNT_W-1:0] r;
        r = base;
        for (int i = 0; i < NWORDS; i++) begin
            if (sel[i]) r[i*WORD_W +: WORD_W] = d;
        end
        return r;
    endfunction

endpackage

// File: rtl/gcnt_regs.sv
module gcnt_regs
    import gcnt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic [CNT_W-1:0]  cmp,
    input  logic              status,
    output wr_strobe_t        wr,
    output ctrl_t             ctrl,
    output logic [WORD_W-1:0] step,
    output logic [WORD_W-1:0] rdata
);

    reg_sel_e sel;
    logic     we;

    assign sel = decode_addr(bus_addr);
    assign we  = bus_sel && bus_wr;

    always_comb begin
        wr = '0;
        if (we) begin
            unique case (sel)
                RG_CNT_LO: wr.cnt_lo = 1'b1;
                RG_CNT_HI: wr.cnt_hi = 1'b1;
                RG_CTRL:   wr.ctrl   = 1'b1;
                RG_STAT:   wr.stat   = 1'b1;
                RG_CMP_LO: wr.cmp_lo = 1'b1;
                RG_CMP_HI: wr.cmp_hi = 1'b1;
                RG_STEP:   wr.step   = 1'b1;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            step <= '0;
        end else begin
            if (wr.ctrl) begin
                ctrl.prescale <= bus_wdata[PRE_LSB +: PRE_W];
                ctrl.step_en  <= bus_wdata[3];
                ctrl.irq_en   <= bus_wdata[2];
                ctrl.cmp_en   <= bus_wdata[1];
                ctrl.run      <= bus_wdata[0];
            end
            if (wr.step) step <= bus_wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (sel)
                RG_CNT_LO: rdata = count[0 +: WORD_W];
                RG_CNT_HI: rdata = count[WORD_W +: WORD_W];
                RG_CTRL:   rdata = ctrl_pack(ctrl);
                RG_STAT:   rdata = {{(WORD_W-1){1'b0}}, status};
                RG_CMP_LO: rdata = cmp[0 +: WORD_W];
                RG_CMP_HI: rdata = cmp[WORD_W +: WORD_W];
                RG_STEP:   rdata = step;
                default:   rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/gcnt_prescale.sv
module gcnt_prescale
    import gcnt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [PRE_W-1:0] div_max,
    output logic             tick
);

    logic [PRE_W-1:0] phase_q;

    assign tick = run && (phase_q == div_max);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase_q <= '0;
        end else if (phase_q == div_max) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/gcnt_counter.sv
module gcnt_counter
    import gcnt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              tick,
    input  logic [NWORDS-1:0] wr_word,
    input  logic [WORD_W-1:0] wdata,
    output logic [CNT_W-1:0]  count
);

    logic [CNT_W-1:0] count_nxt;

    always_comb begin
        count_nxt = count;
        if (!run) begin
            count_nxt = merge_words(count, wr_word, wdata);
        end else if (tick) begin
            count_nxt = count + {{(CNT_W-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count_nxt;
    end

endmodule

// File: rtl/gcnt_compare.sv
module gcnt_compare
    import gcnt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  count,
    input  logic              cmp_en,
    input  logic              step_en,
    input  logic [WORD_W-1:0] step,
    input  logic [NWORDS-1:0] wr_word,
    input  logic              wr_stat,
    input  logic [WORD_W-1:0] wdata,
    output logic [CNT_W-1:0]  cmp,
    output logic              status
);

    logic             hit;
    logic [CNT_W-1:0] stepped;
    logic [CNT_W-1:0] cmp_nxt;

    assign hit     = cmp_en && (count >= cmp);
    assign stepped = cmp + {{(CNT_W-WORD_W){1'b0}}, step};

    always_comb begin
        cmp_nxt = (hit && step_en) ? stepped : cmp;
        cmp_nxt = merge_words(cmp_nxt, wr_word, wdata);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp    <= '0;
            status <= 1'b0;
        end else begin
            cmp <= cmp_nxt;
            if (hit)                    status <= 1'b1;
            else if (wr_stat && wdata[0]) status <= 1'b0;
        end
    end

endmodule

// File: rtl/gcnt_timer.sv
module gcnt_timer
    import gcnt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq
);

    wr_strobe_t        wr;
    ctrl_t             ctrl_q;
    logic [WORD_W-1:0] step_q;
    logic [CNT_W-1:0]  count_q;
    logic [CNT_W-1:0]  cmp_q;
    logic              stat_q;
    logic              tick;

    gcnt_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .count     (count_q),
        .cmp       (cmp_q),
        .status    (stat_q),
        .wr        (wr),
        .ctrl      (ctrl_q),
        .step      (step_q),
        .rdata     (bus_rdata)
    );

    gcnt_prescale u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl_q.run),
        .div_max (ctrl_q.prescale),
        .tick    (tick)
    );

    gcnt_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl_q.run),
        .tick    (tick),
        .wr_word ({wr.cnt_hi, wr.cnt_lo}),
        .wdata   (bus_wdata),
        .count   (count_q)
    );

    gcnt_compare u_cmp (
        .clk     (clk),
        .rst     (rst),
        .count   (count_q),
        .cmp_en  (ctrl_q.cmp_en),
        .step_en (ctrl_q.step_en),
        .step    (step_q),
        .wr_word ({wr.cmp_hi, wr.cmp_lo}),
        .wr_stat (wr.stat),
        .wdata   (bus_wdata),
        .cmp     (cmp_q),
        .status  (stat_q)
    );

    assign irq = stat_q && ctrl_q.irq_en;

endmodule

// File: rtl/gcnt_timer_chk.sv
module gcnt_timer_chk
    import gcnt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              clr_bit,
    input logic              irq,
    input ctrl_t             ctrl,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  cmp,
    input logic              status
);

    logic cnt_write;
    logic cmp_write;
    logic clr_write;

    assign cnt_write = bus_sel && bus_wr && (bus_addr == 5'h00 || bus_addr == 5'h04);
    assign cmp_write = bus_sel && bus_wr && (bus_addr == 5'h10 || bus_addr == 5'h14);
    assign clr_write = bus_sel && bus_wr && (bus_addr == 5'h0C) && clr_bit;

    AST_COUNT_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
        ctrl.run |=> (count == $past(count) || count == $past(count) + 64'd1)); // R3

    AST_COUNT_SPACED: assert property (@(posedge clk) disable iff (rst)
        (ctrl.run && ctrl.prescale != '0 && count != $past(count)) |=> (count == $past(count))); // R3

    AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.run && !cnt_write) |=> $stable(count)); // R9

    AST_MATCH_SETS: assert property (@(posedge clk) disable iff (rst)
        (ctrl.cmp_en && count >= cmp) |=> status); // R5

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (status && !clr_write) |=> status); // R6

    AST_CMP_FIXED: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.step_en && !cmp_write) |=> $stable(cmp)); // R7

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (status && ctrl.irq_en)); // R8

endmodule

bind gcnt_timer gcnt_timer_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .clr_bit  (bus_wdata[0]),
    .irq      (irq),
    .ctrl     (ctrl_q),
    .count    (count_q),
    .cmp      (cmp_q),
    .status   (stat_q)
);

// File: tb/tb_gcnt_timer.sv
module tb_gcnt_timer;

    localparam int CLK_PERIOD = 10;

    localparam logic [4:0] A_CLO  = 5'h00;
    localparam logic [4:0] A_CHI  = 5'h04;
    localparam logic [4:0] A_CTL  = 5'h08;
    localparam logic [4:0] A_STA  = 5'h0C;
    localparam logic [4:0] A_MLO  = 5'h10;
    localparam logic [4:0] A_MHI  = 5'h14;
    localparam logic [4:0] A_STP  = 5'h18;

    localparam int NVEC = 5;
    localparam logic [7:0]  V_PRE  [NVEC] = '{8'd0, 8'd3, 8'd1, 8'd255, 8'd4};
    localparam logic [63:0] V_LOAD [NVEC] = '{64'd0, 64'd100, 64'h0000_0000_FFFF_FFFE, 64'd5, 64'd0};
    localparam int          V_WAIT [NVEC] = '{9, 11, 5, 511, 3};
    localparam logic [63:0] V_EXP  [NVEC] = '{64'd10, 64'd103, 64'h0000_0001_0000_0001, 64'd7, 64'd0};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;

    gcnt_timer dut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%h expected=%h", req, got, exp);
        end
    endtask

    // called at a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
        #1;
    endtask

    task automatic rd64(input logic [4:0] a, output logic [63:0] d);
        logic [31:0] lo, hi;
        rd(a, lo);
        rd(a + 5'd4, hi);
        d = {hi, lo};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: got=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] w;
        logic [63:0] v;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(5'(a * 4), w);
            check("R1 reset read", {32'd0, w}, 64'd0);
        end
        check("R1 irq after reset", {63'd0, irq}, 64'd0);

        // R3 table: load, run for a measured number of edges, stop, read
        for (int i = 0; i < NVEC; i++) begin
            wr(A_CTL, 32'h0);
            wr(A_CLO, V_LOAD[i][31:0]);
            wr(A_CHI, V_LOAD[i][63:32]);
            wr(A_CTL, {16'h0, V_PRE[i], 8'h01});
            repeat (V_WAIT[i]) @(negedge clk);
            wr(A_CTL, 32'h0);
            rd64(A_CLO, v);
            check("R3 count after run", v, V_EXP[i]);
        end

        // R4 write while running is ignored; R9 stopped count holds
        wr(A_CLO, 32'h0);
        wr(A_CHI, 32'h0);
        wr(A_CTL, 32'h1);
        wr(A_CLO, 32'h0000_DEAD);
        wr(A_CTL, 32'h0);
        rd64(A_CLO, v);
        check("R4 running write ignored", v, 64'd2);
        repeat (5) @(negedge clk);
        rd64(A_CLO, v);
        check("R9 stopped count holds", v, 64'd2);

        // R5 / R8 match timing
        wr(A_CLO, 32'h0);
        wr(A_MLO, 32'd10);
        wr(A_MHI, 32'd0);
        wr(A_CTL, 32'h7);
        repeat (9) @(negedge clk);
        rd(A_STA, w);
        check("R5 no flag below compare", {32'd0, w}, 64'd0);
        @(negedge clk);
        rd(A_STA, w);
        check("R5 flag one edge after equal", {32'd0, w}, 64'd0);
        @(negedge clk);
        rd(A_STA, w);
        check("R5 flag set after match", {32'd0, w}, 64'd1);
        check("R8 irq with flag and enable", {63'd0, irq}, 64'd1);

        // R6 write of zero, R8 gating, R6 clear
        wr(A_CTL, 32'h4);
        wr(A_STA, 32'h0);
        rd(A_STA, w);
        check("R6 zero write no effect", {32'd0, w}, 64'd1);
        wr(A_CTL, 32'h0);
        check("R8 irq masked by enable", {63'd0, irq}, 64'd0);
        wr(A_STA, 32'h1);
        rd(A_STA, w);
        check("R6 write one clears", {32'd0, w}, 64'd0);

        // R6 set wins over clear
        wr(A_CTL, 32'h2);
        wr(A_STA, 32'h1);
        rd(A_STA, w);
        check("R6 match beats clear", {32'd0, w}, 64'd1);
        wr(A_CTL, 32'h0);
        wr(A_STA, 32'h1);
        rd(A_STA, w);
        check("R6 clear after compare off", {32'd0, w}, 64'd0);

        // R7 auto-increment schedule
        wr(A_CLO, 32'h0);
        wr(A_CHI, 32'h0);
        wr(A_MLO, 32'd5);
        wr(A_STP, 32'd7);
        wr(A_CTL, 32'hB);
        repeat (14) @(negedge clk);
        wr(A_CTL, 32'h0);
        rd64(A_MLO, v);
        check("R7 comparator after two steps", v, 64'd19);
        rd64(A_CLO, v);
        check("R3 count during step run", v, 64'd15);

        // R7 bus write beats the step
        wr(A_MLO, 32'd3);
        wr(A_CTL, 32'hA);
        wr(A_MLO, 32'd100);
        wr(A_CTL, 32'h0);
        rd64(A_MLO, v);
        check("R7 bus write wins over step", v, 64'd100);
        wr(A_STA, 32'h1);

        // R2 layout and unmapped addresses
        wr(A_CTL, 32'hFFFF_FFF0);
        rd(A_CTL, w);
        check("R2 control reserved bits zero", {32'd0, w}, 64'h0000_FF00);
        wr(5'h09, 32'h0000_0001);
        rd(A_CTL, w);
        check("R2 misaligned write ignored", {32'd0, w}, 64'h0000_FF00);
        wr(A_CTL, 32'h0);
        wr(A_MHI, 32'hA5A5_0001);
        rd(A_MHI, w);
        check("R2 comparator high word", {32'd0, w}, 64'h0000_0000_A5A5_0001);
        rd(A_STP, w);
        check("R2 step readback", {32'd0, w}, 64'd7);
        wr(5'h1C, 32'hFFFF_FFFF);
        rd(5'h1C, w);
        check("R2 unmapped reads zero", {32'd0, w}, 64'd0);
        rd(5'h0A, w);
        check("R2 misaligned read zero", {32'd0, w}, 64'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule